// File: doc/BRIEF.md
# Calendar real-time clock with shadowed register access

This block keeps calendar time: seconds, minutes, hours, weekday, day of month, month and two-digit year. It advances on a clock-enable tick that arrives at 32.768 kHz. A free-running prescaler divides that tick into two rates. A fast refresh tick runs at 512 Hz by default. A slower sub-second tick runs at 128 Hz. The sub-second tick drives a countdown to the next second boundary. Every time that countdown wraps, the live counters advance by one second and a one-cycle pulse is issued. The whole carry chain up to the year settles within that one cycle.

Software never touches the live counters directly. It works through a bank of shadow words on a simple register bus. On each refresh tick the shadow bank copies the live time, unless software has asked to hold it.

- A freeze bit holds the snapshot still so software can read it.
- A commit bit opens the shadow bank for writing.
- When the commit bit is dropped, only the shadow words written in the meantime are loaded into the live counters, on the next refresh tick.
- Both bits read back as one until the live side has caught up.

Top module: `rtc_shadow_calendar`

## Requirements
- R1: After power-on reset (`por_n` low), the calendar reads 00:00:00, weekday 1, day 1, month 1, year 0. The control word at address 8 reads 0.
- R2: Register map:
  - Addresses 0..6 hold the shadow words, in this order: second, minute, hour, weekday, day of month, month, year.
  - Address 8 is the control word: bit 0 is the freeze bit, bit 1 is the commit bit.
  - Address 9 is the sub-second count.
  - A bus write to addresses 0..6 while the commit bit is 0 is ignored.
- R3: While the freeze bit is 1, the shadow words do not change. After the freeze bit is written to 0, control bit 0 keeps reading 1 until the next refresh, which happens every 2^REF_LOG2 ticks. After that refresh the shadow follows the live time again.
- R4: After the commit bit is written from 1 to 0, control bit 1 keeps reading 1 until the next refresh tick. On that tick the written words reach the live counters and the bit reads 0.
- R5: A bus write to a shadow word sets that word's change flag. A commit loads only the flagged words and clears every flag. Unflagged live words keep counting.
- R6: Seconds and minutes roll over 59→0, hours 23→0, weekday 7→1, month 12→1, year 99→0. Every carry the roll-over causes is applied in the same cycle.
- R7: The day of month rolls to 1 after the last day of its month:
  - 30 days in April, June, September and November.
  - 31 days in the other months except February.
  - February has 29 days when year mod 4 is 0, otherwise 28.
- R8: Address 9 counts down from SUB_COUNT-1 to 0, stepping once per 2^SUB_LOG2 ticks. Writing 0x00 there reloads SUB_COUNT-1 and restarts the prescaler. Writing any nonzero value there is ignored.
- R9: `rst_n` clears the freeze bit, the commit bit, their pending states and the change flags. It leaves the live counters, the shadow words and the prescaler untouched. Only `por_n` initialises those.
- R10: `sec_pulse` is high for exactly one cycle per second, that is once per SUB_COUNT·2^SUB_LOG2 ticks, in the cycle after the sub-second count wraps. After a restart write to address 9, the first pulse comes that many ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; initialises the calendar |
| rst_n | input | 1 | System reset, active low; clears only the control state |
| tick_32k | input | 1 | 32.768 kHz clock-enable tick |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sec_pulse | output | 1 | One-cycle pulse at each second boundary |

## Verification
The checker watches the following on every cycle:
- the shadow bank stays still while frozen with the commit bit low;
- a pending commit survives until a refresh tick;
- a commit leaves all change flags clear;
- a restart write reloads the sub-second count;
- the second pulse lasts one cycle and coincides with a freshly reloaded count.

Only the bench scenarios can show the calendar arithmetic: the cascaded roll-overs, the month lengths and the leap-year February. The same holds for the selective commit, which keeps a counting second while loading a new minute. The bench also covers the exact second period after a restart and what survives a system reset compared with a power-on reset.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NUM_WORDS = 7;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] minute;
        logic [5:0] second;
    } cal_t;

    typedef struct packed {
        cal_t                 live;
        cal_t                 shadow;
        logic [NUM_WORDS-1:0] dirty;
        logic                 freeze;
        logic                 freeze_wait;
        logic                 commit;
        logic                 commit_wait;
        logic                 pulse;
    } rtc_state_t;

    localparam cal_t CAL_INIT = '{year: 7'd0, month: 4'd1, mday: 5'd1, wday: 3'd1,
                                  hour: 5'd0, minute: 6'd0, second: 6'd0};

    function automatic logic [4:0] days_in_month(logic [3:0] m, logic [6:0] y);
        logic [4:0] n;
        case (m)
            4'd2:                    n = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: n = 5'd30;
            default:                 n = 5'd31;
        endcase
        return n;
    endfunction

    function automatic logic [7:0] word_get(cal_t c, logic [2:0] idx);
        logic [7:0] v;
        case (idx)
            3'd0:    v = {2'b0, c.second};
            3'd1:    v = {2'b0, c.minute};
            3'd2:    v = {3'b0, c.hour};
            3'd3:    v = {5'b0, c.wday};
            3'd4:    v = {3'b0, c.mday};
            3'd5:    v = {4'b0, c.month};
            3'd6:    v = {1'b0, c.year};
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic cal_t word_set(cal_t c, logic [2:0] idx, logic [7:0] v);
        cal_t r;
        r = c;
        case (idx)
            3'd0:    r.second = v[5:0];
            3'd1:    r.minute = v[5:0];
            3'd2:    r.hour   = v[4:0];
            3'd3:    r.wday   = v[2:0];
            3'd4:    r.mday   = v[4:0];
            3'd5:    r.month  = v[3:0];
            3'd6:    r.year   = v[6:0];
            default: r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int SUB_LOG2 = 8,
    parameter int REF_LOG2 = 6
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick_en,
    input  logic realign,
    output logic refresh_tick,
    output logic sub_tick
);
    logic [SUB_LOG2-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (realign) begin
            cnt_d = '0;
        end else if (tick_en) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign refresh_tick = tick_en && (cnt_q[REF_LOG2-1:0] == {REF_LOG2{1'b1}});
    assign sub_tick     = tick_en && (cnt_q == {SUB_LOG2{1'b1}});
endmodule

// File: rtl/rtc_subsecond.sv
module rtc_subsecond #(
    parameter int SUB_COUNT = 128,
    localparam int SUBW     = $clog2(SUB_COUNT)
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            sub_tick,
    input  logic            restart,
    output logic [SUBW-1:0] count,
    output logic            wrap
);
    localparam logic [SUBW-1:0] TOP = SUBW'(SUB_COUNT - 1);

    logic [SUBW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = TOP;
        end else if (sub_tick) begin
            cnt_d = (cnt_q == '0) ? TOP : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q <= TOP;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
    assign wrap  = sub_tick && !restart && (cnt_q == '0);
endmodule

// File: rtl/rtc_calendar_step.sv
module rtc_calendar_step
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic carry_min, carry_hour, carry_day, carry_mon, carry_year;

    always_comb begin
        nxt        = cur;
        carry_min  = (cur.second == 6'd59);
        carry_hour = carry_min && (cur.minute == 6'd59);
        carry_day  = carry_hour && (cur.hour == 5'd23);
        carry_mon  = carry_day && (cur.mday >= days_in_month(cur.month, cur.year));
        carry_year = carry_mon && (cur.month >= 4'd12);

        nxt.second = carry_min ? 6'd0 : cur.second + 6'd1;
        if (carry_min) begin
            nxt.minute = carry_hour ? 6'd0 : cur.minute + 6'd1;
        end
        if (carry_hour) begin
            nxt.hour = carry_day ? 5'd0 : cur.hour + 5'd1;
        end
        if (carry_day) begin
            nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
            nxt.mday = carry_mon ? 5'd1 : cur.mday + 5'd1;
        end
        if (carry_mon) begin
            nxt.month = carry_year ? 4'd1 : cur.month + 4'd1;
        end
        if (carry_year) begin
            nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
        end
    end
endmodule

// File: rtl/rtc_shadow_calendar.sv
module rtc_shadow_calendar
    import rtc_cal_pkg::*;
#(
    parameter int SUB_COUNT = 128,
    parameter int SUB_LOG2  = 8,
    parameter int REF_LOG2  = 6,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              sec_pulse
);
    localparam int SUBW = $clog2(SUB_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_SUB   = ADDR_W'(9);
    localparam logic [ADDR_W-1:0] A_WORDS = ADDR_W'(NUM_WORDS);

    rtc_state_t st_d, st_q;

    logic            refresh_tick, sub_tick, wrap, restart;
    logic [SUBW-1:0] sub_count;
    logic            commit_apply, refresh_now, shadow_wr;
    cal_t            stepped;

    logic                 freeze_q, commit_q, commit_wait_q;
    logic [NUM_WORDS-1:0] dirty_q;
    logic [$bits(cal_t)-1:0] shadow_bits;

    assign restart = bus_wr && (bus_addr == A_SUB) && (bus_wdata == 8'h00);

    rtc_prescaler #(.SUB_LOG2(SUB_LOG2), .REF_LOG2(REF_LOG2)) u_presc (
        .clk          (clk),
        .por_n        (por_n),
        .tick_en      (tick_32k),
        .realign      (restart),
        .refresh_tick (refresh_tick),
        .sub_tick     (sub_tick)
    );

    rtc_subsecond #(.SUB_COUNT(SUB_COUNT)) u_sub (
        .clk      (clk),
        .por_n    (por_n),
        .sub_tick (sub_tick),
        .restart  (restart),
        .count    (sub_count),
        .wrap     (wrap)
    );

    rtc_calendar_step u_step (
        .cur (st_q.live),
        .nxt (stepped)
    );

    assign shadow_wr    = bus_wr && st_q.commit && (bus_addr < A_WORDS);
    assign commit_apply = st_q.commit_wait && refresh_tick;
    assign refresh_now  = refresh_tick && !st_q.freeze && !st_q.commit && !st_q.commit_wait;

    always_comb begin
        st_d = st_q;

        // live counters: advance on wrap, then overlay committed words
        st_d.live  = wrap ? stepped : st_q.live;
        st_d.pulse = wrap;
        if (commit_apply) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (st_q.dirty[i]) begin
                    st_d.live = word_set(st_d.live, 3'(i), word_get(st_q.shadow, 3'(i)));
                end
            end
            st_d.dirty       = '0;
            st_d.commit_wait = 1'b0;
        end

        // shadow refresh from live side
        if (refresh_now) begin
            st_d.shadow      = st_q.live;
            st_d.freeze_wait = 1'b0;
        end

        // processor writes into the shadow bank
        if (shadow_wr) begin
            st_d.shadow = word_set(st_q.shadow, bus_addr[2:0], bus_wdata);
            st_d.dirty[bus_addr[2:0]] = 1'b1;
        end

        // control word
        if (bus_wr && (bus_addr == A_CTRL)) begin
            st_d.freeze = bus_wdata[0];
            st_d.commit = bus_wdata[1];
            if (st_q.freeze && !bus_wdata[0]) begin
                st_d.freeze_wait = 1'b1;
            end
            if (st_q.commit && !bus_wdata[1]) begin
                st_d.commit_wait = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.live        <= CAL_INIT;
            st_q.shadow      <= CAL_INIT;
            st_q.dirty       <= '0;
            st_q.freeze      <= 1'b0;
            st_q.freeze_wait <= 1'b0;
            st_q.commit      <= 1'b0;
            st_q.commit_wait <= 1'b0;
            st_q.pulse       <= 1'b0;
        end else if (!rst_n) begin
            st_q.live        <= st_d.live;
            st_q.shadow      <= st_q.shadow;
            st_q.dirty       <= '0;
            st_q.freeze      <= 1'b0;
            st_q.freeze_wait <= 1'b0;
            st_q.commit      <= 1'b0;
            st_q.commit_wait <= 1'b0;
            st_q.pulse       <= st_d.pulse;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr < A_WORDS) begin
            bus_rdata = word_get(st_q.shadow, bus_addr[2:0]);
        end else if (bus_addr == A_CTRL) begin
            bus_rdata = {6'b0, st_q.commit | st_q.commit_wait, st_q.freeze | st_q.freeze_wait};
        end else if (bus_addr == A_SUB) begin
            bus_rdata = 8'(sub_count);
        end
    end

    assign sec_pulse     = st_q.pulse;
    assign freeze_q      = st_q.freeze;
    assign commit_q      = st_q.commit;
    assign commit_wait_q = st_q.commit_wait;
    assign dirty_q       = st_q.dirty;
    assign shadow_bits   = st_q.shadow;
endmodule

// File: rtl/rtc_shadow_calendar_checker.sv
module rtc_shadow_calendar_checker #(
    parameter int SUB_COUNT = 128,
    parameter int ADDR_W    = 4,
    parameter int SHW       = 36,
    localparam int SUBW     = $clog2(SUB_COUNT)
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic              sec_pulse,
    input logic [SUBW-1:0]   sub_count,
    input logic              freeze_q,
    input logic              commit_q,
    input logic              commit_wait_q,
    input logic              refresh_tick,
    input logic              commit_apply,
    input logic [6:0]        dirty_q,
    input logic [SHW-1:0]    shadow_bits
);
    // R3: frozen snapshot with the bank closed for writing never moves
    p_frozen_stable_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (freeze_q && !commit_q) |=> $stable(shadow_bits));

    // R4: a pending commit stays pending until a refresh tick takes it
    p_commit_hold_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (commit_wait_q && !refresh_tick) |=> commit_wait_q);

    // R5: change flags are empty after a commit lands
    p_flags_clear_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (commit_apply && !commit_q) |=> (dirty_q == '0));

    // R8: restart write reloads the countdown
    p_restart_r8: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && (bus_addr == ADDR_W'(9)) && (bus_wdata == 8'h00))
            |=> (sub_count == SUBW'(SUB_COUNT - 1)));

    // R10: second pulse is one cycle wide and follows a fresh reload
    p_pulse_width_r10: assert property (@(posedge clk) disable iff (!por_n)
        sec_pulse |=> !sec_pulse);

    p_pulse_reload_r10: assert property (@(posedge clk) disable iff (!por_n)
        sec_pulse |-> (sub_count == SUBW'(SUB_COUNT - 1)));
endmodule

bind rtc_shadow_calendar rtc_shadow_calendar_checker #(
    .SUB_COUNT (SUB_COUNT),
    .ADDR_W    (ADDR_W),
    .SHW       ($bits(rtc_cal_pkg::cal_t))
) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_wr        (bus_wr),
    .sec_pulse     (sec_pulse),
    .sub_count     (sub_count),
    .freeze_q      (freeze_q),
    .commit_q      (commit_q),
    .commit_wait_q (commit_wait_q),
    .refresh_tick  (refresh_tick),
    .commit_apply  (commit_apply),
    .dirty_q       (dirty_q),
    .shadow_bits   (shadow_bits)
);

// File: tb/rtc_shadow_calendar_test.sv
module rtc_shadow_calendar_test;
    localparam int SUB_COUNT = 4;
    localparam int SUB_LOG2  = 3;
    localparam int REF_LOG2  = 2;
    localparam int SEC_CYC   = SUB_COUNT * (1 << SUB_LOG2);

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0, tick_32k = 1'b1;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic       sec_pulse;

    always #5 clk = ~clk;

    rtc_shadow_calendar #(.SUB_COUNT(SUB_COUNT), .SUB_LOG2(SUB_LOG2),
                          .REF_LOG2(REF_LOG2), .ADDR_W(4)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_32k(tick_32k),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .sec_pulse(sec_pulse)
    );

    typedef struct { logic [3:0] a; logic [7:0] e; string tag; } item_t;
    item_t sb[$];
    int checks = 0;
    int fails  = 0;

    // monitor: samples 3 ns after each rising edge, away from the edge
    always @(posedge clk) begin
        item_t it;
        #3;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (bus_rdata !== it.e) begin
                fails++;
                $display("FAIL %s: addr %0d got %0d expected %0d", it.tag, it.a, bus_rdata, it.e);
            end
        end
    end

    task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
        bus_addr = a;
        sb.push_back('{a: a, e: e, tag: tag});
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic check_now(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic get_reg(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!sec_pulse);
    endtask

    task automatic wait_commit(input string tag);
        logic [7:0] v;
        int n;
        n = 0;
        get_reg(4'd8, v);
        while (v[1] && n < 20) begin
            @(negedge clk);
            n++;
            get_reg(4'd8, v);
        end
        check_now(int'(v[1]), 0, tag);
    endtask

    task automatic set_time(input int s, input int m, input int h, input int wd,
                            input int md, input int mo, input int y);
        wait_pulse();
        wr(4'd8, 8'h02);
        wr(4'd0, 8'(s)); wr(4'd1, 8'(m)); wr(4'd2, 8'(h)); wr(4'd3, 8'(wd));
        wr(4'd4, 8'(md)); wr(4'd5, 8'(mo)); wr(4'd6, 8'(y));
        wr(4'd8, 8'h00);
        expect_reg(4'd8, 8'h02, "R4 commit reads busy");
        wait_commit("R4 commit completes");
    endtask

    task automatic freeze_after_pulse();
        wait_pulse();
        repeat (6) @(negedge clk);
        wr(4'd8, 8'h01);
    endtask

    task automatic expect_cal(input int s, input int m, input int h, input int wd,
                              input int md, input int mo, input int y, input string tag);
        expect_reg(4'd0, 8'(s), tag);  expect_reg(4'd1, 8'(m), tag);
        expect_reg(4'd2, 8'(h), tag);  expect_reg(4'd3, 8'(wd), tag);
        expect_reg(4'd4, 8'(md), tag); expect_reg(4'd5, 8'(mo), tag);
        expect_reg(4'd6, 8'(y), tag);
    endtask

    task automatic rollover(input int s, input int m, input int h, input int wd,
                            input int md, input int mo, input int y,
                            input int es, input int em, input int eh, input int ewd,
                            input int emd, input int emo, input int ey, input string tag);
        set_time(s, m, h, wd, md, mo, y);
        freeze_after_pulse();
        expect_cal(es, em, eh, ewd, emd, emo, ey, tag);
        wait_pulse();
        wr(4'd8, 8'h00);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v, v0;
        int n;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1: power-on state
        expect_reg(4'd8, 8'h00, "R1 control after POR");
        expect_cal(0, 0, 0, 1, 1, 1, 0, "R1 calendar after POR");

        // R10: pulse period
        wait_pulse();
        n = 0;
        do begin @(negedge clk); n++; end while (!sec_pulse);
        check_now(n, SEC_CYC, "R10 pulse period");

        // R6: full cascade through year
        rollover(59, 59, 23, 7, 31, 12, 99, 0, 0, 0, 1, 1, 1, 0, "R6 year wrap");
        rollover(59, 59, 9, 2, 15, 6, 20, 0, 0, 10, 2, 15, 6, 20, "R6 hour carry");
        // R7: month lengths and leap years
        rollover(59, 59, 23, 3, 28, 2, 4, 0, 0, 0, 4, 29, 2, 4, "R7 leap Feb 28");
        rollover(59, 59, 23, 3, 29, 2, 4, 0, 0, 0, 4, 1, 3, 4, "R7 leap Feb 29");
        rollover(59, 59, 23, 5, 28, 2, 5, 0, 0, 0, 6, 1, 3, 5, "R7 plain Feb 28");
        rollover(59, 59, 23, 6, 30, 4, 10, 0, 0, 0, 7, 1, 5, 10, "R7 April 30");

        // R5: partial commit, second keeps counting
        set_time(5, 20, 10, 2, 15, 6, 20);
        wait_pulse();
        wr(4'd8, 8'h02);
        wr(4'd1, 8'd17);
        wr(4'd8, 8'h00);
        wait_commit("R5 partial commit completes");
        repeat (6) @(negedge clk);
        wr(4'd8, 8'h01);
        expect_cal(6, 17, 10, 2, 15, 6, 20, "R5 only flagged word loaded");

        // R2: shadow write ignored while commit bit is 0
        get_reg(4'd0, v0);
        @(negedge clk);
        wr(4'd0, 8'd33);
        expect_reg(4'd0, v0, "R2 write without commit ignored");
        // R3: frozen across a second boundary
        repeat (40) @(negedge clk);
        expect_reg(4'd0, v0, "R3 frozen snapshot");
        expect_reg(4'd8, 8'h01, "R3 freeze bit reads 1");
        wait_pulse();
        wr(4'd8, 8'h00);
        expect_reg(4'd8, 8'h01, "R3 freeze release pending");
        repeat (6) @(negedge clk);
        expect_reg(4'd8, 8'h00, "R3 freeze released");
        get_reg(4'd0, v);
        check_now(int'(v != v0), 1, "R3 shadow follows again");

        // R8: restart and ignored nonzero write
        @(negedge clk);
        wr(4'd9, 8'h00);
        wr(4'd9, 8'h05);
        get_reg(4'd9, v);
        check_now(int'(v), SUB_COUNT - 1, "R8 restart reload");
        n = 0;
        do begin @(negedge clk); n++; end while (!sec_pulse);
        check_now(n, SEC_CYC - 1, "R8/R10 first pulse after restart");

        // R9: system reset keeps time, clears control
        set_time(0, 30, 8, 1, 10, 3, 22);
        wr(4'd8, 8'h02);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        get_reg(4'd8, v);
        check_now(int'(v), 0, "R9 control cleared by rst_n");
        repeat (6) @(negedge clk);
        wr(4'd8, 8'h01);
        expect_reg(4'd2, 8'd8, "R9 hour kept");
        expect_reg(4'd1, 8'd30, "R9 minute kept");
        wr(4'd8, 8'h00);

        // R1: power-on reset re-initialises
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        expect_reg(4'd2, 8'd0, "R1 hour after second POR");
        expect_reg(4'd5, 8'd1, "R1 month after second POR");
        expect_reg(4'd8, 8'h00, "R1 control after second POR");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule